// File: doc/BRIEF.md
# Interrupt Aggregator with Hold-off Timer

This block collects ten peripheral interrupt sources and drives one interrupt request line toward the host. The sources are a PHY, a DMA engine, a general-purpose timer, three GPIO pins, a software request, a master bus error, a slave bus error and a wake event. Some sources are captured in sticky status bits that software must clear. The rest are shown live in the status register and cannot be cleared by a write.

Three registers are reached through a small word-addressed read/write port: status, enable and configuration. The configuration register holds an 8-bit interval. After the request line drops, the line stays low for that many prescaled ticks, even if a source asks again. This guarantees the host a minimum low time between requests. A status bit shows whether the hold-off is running, and a write-1 bit ends it early.

Register map (word address on `reg_addr`). Address 0 is status. Address 1 is enable. Address 2 is configuration. Address 3 reads as zero.

Status and enable use the same bit positions:

| Bit | Source |
|-----|--------|
| 0 | PHY |
| 1 | DMA |
| 2 | GPIO0 |
| 3 | GPIO1 |
| 4 | GPIO2 |
| 5 | software request |
| 6 | general-purpose timer |
| 7 | master bus error |
| 8 | slave bus error |
| 9 | wake |

The enable register also has two control bits:
- Bit 16 is a write-1 software request. It always reads 0.
- Bit 31 is the global request enable.

The configuration register has three fields:
- Bits 7:0 hold the hold-off interval.
- Bit 8 is the read-only "hold-off running" flag.
- Bit 9 is a write-1 early clear. It always reads 0.

Top module: `irq_gather`

## Requirements
- R1: Every status bit (address 0) shows its source state regardless of the enable register. Enable bits only affect `irq_o`.
- R2: Status bits 2..8 are sticky. Each stays set until a write to address 0 with a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R3: A GPIO status bit (bits 2..4 for GPIO0..2) is set by a low-to-high transition of its `gpio_in` line. A GPIO line that stays high does not set the bit again after it is cleared.
- R4: Status bits 0 (PHY), 1 (DMA) and 9 (wake) follow `phy_irq`, `dma_irq` and `wake_irq` in the same cycle. A write of 1 to them has no effect.
- R5: Writing 1 to bit 16 of address 1 sets status bit 5. Bit 16 reads back as 0.
- R6: `irq_o` is a register. After each clock edge it equals the value, just before that edge, of "OR over all bits of (status AND enable[9:0])" ANDed with enable bit 31. This holds while no hold-off is running.
- R7: When `irq_o` falls and the interval N (address 2 bits 7:0) is nonzero, the hold-off starts. `irq_o` stays low for N*PRESCALE+1 cycles even if the request is present. Address 2 bit 8 reads 1 while the hold-off counter is nonzero.
- R8: An interval of 0 disables the hold-off. `irq_o` rises one cycle after the request returns.
- R9: Writing 1 to bit 9 of address 2 ends a running hold-off. Bit 8 reads 0 after that write, and `irq_o` follows the request from the next edge.
- R10: If a sticky source event and a write-1 clear of the same bit happen in the same cycle, the bit ends up set.
- R11: After reset, all three registers read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| phy_irq | input | 1 | PHY interrupt level |
| dma_irq | input | 1 | DMA interrupt level |
| gpio_in | input | 3 | GPIO input lines |
| gpt_evt | input | 1 | General-purpose timer event |
| mberr_evt | input | 1 | Master bus error event |
| sberr_evt | input | 1 | Slave bus error event |
| wake_irq | input | 1 | Wake event level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with PRESCALE set to 3 and keeps the default 8-bit interval. With these values, the full 255-tick hold-off runs out in 766 cycles, so the bench can check the largest interval end to end. It can also check the exact release cycle of a short interval, which tests the tick boundary on the prescaler. A long random run with the interval at 0 compares the status word and `irq_o` against a bench model every cycle. That run covers mixed edges, levels and same-cycle clears.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int PRESCALE = 250,
  parameter int IVL_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        phy_irq,
  input  logic        dma_irq,
  input  logic [2:0]  gpio_in,
  input  logic        gpt_evt,
  input  logic        mberr_evt,
  input  logic        sberr_evt,
  input  logic        wake_irq,
  output logic        irq_o
);
  localparam int NSRC = 10;
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [NSRC-1:0] STICKY = 10'b01_1111_1100;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [2:0]       gpio_q;
  logic [NSRC-1:0]  sticky_q, en_q, status, set_v, clr_v;
  logic             gen_q, irq_q, raw, hold;
  logic [IVL_W-1:0] ivl_q, cnt_q;
  logic [PS_W-1:0]  pcnt_q;

  wire wr_stat = reg_wr && (reg_addr == 2'd0);
  wire wr_en   = reg_wr && (reg_addr == 2'd1);
  wire wr_cfg  = reg_wr && (reg_addr == 2'd2);
  wire sw_req  = wr_en && reg_wdata[16];
  wire hclr    = wr_cfg && reg_wdata[9];

  assign set_v  = {1'b0, sberr_evt, mberr_evt, gpt_evt, sw_req, gpio_in & ~gpio_q, 2'b00};
  assign clr_v  = wr_stat ? (reg_wdata[NSRC-1:0] & STICKY) : '0;
  assign status = (sticky_q & STICKY) | {wake_irq, 7'b0, dma_irq, phy_irq};
  assign raw    = (|(status & en_q)) & gen_q;
  assign hold   = (cnt_q != '0);
  assign irq_o  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_q   <= '0;
      sticky_q <= '0;
      en_q     <= '0;
      gen_q    <= 1'b0;
      ivl_q    <= '0;
    end else begin
      gpio_q   <= gpio_in;
      sticky_q <= ((sticky_q & ~clr_v) | set_v) & STICKY;
      if (wr_en) begin
        en_q  <= reg_wdata[NSRC-1:0];
        gen_q <= reg_wdata[31];
      end
      if (wr_cfg) ivl_q <= reg_wdata[IVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= raw & ~hold;
      if (hclr) begin
        cnt_q  <= '0;
        pcnt_q <= '0;
      end else if (irq_q && !raw) begin
        cnt_q  <= ivl_q;
        pcnt_q <= '0;
      end else if (hold) begin
        if (pcnt_q == PS_LAST) begin
          pcnt_q <= '0;
          cnt_q  <= cnt_q - 1'b1;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {22'b0, status};
      2'd1:    reg_rdata = {gen_q, 21'b0, en_q};
      2'd2:    reg_rdata = {23'b0, hold, 8'(ivl_q)};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [2:0]  gpio_in,
  input logic        gpt_evt,
  input logic        irq_o,
  input logic [9:0]  status,
  input logic [9:0]  en,
  input logic        gen,
  input logic        hold
);
  localparam logic [9:0] STK = 10'b01_1111_1100;
  logic [9:0] clr_now;
  assign clr_now = (reg_wr && reg_addr == 2'd0) ? reg_wdata[9:0] : 10'b0;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((STK & $past(status) & ~$past(clr_now) & ~status) == 10'b0)); // R2
  AST_GPIO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(status[2]) |-> $past(gpio_in[0])); // R3
  AST_IRQ_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq_o |-> $past(gen)); // R6
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq_o |-> $past(|(status & en))); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !irq_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(gpt_evt) |-> status[6]); // R10
endmodule

bind irq_gather irq_gather_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .gpio_in(gpio_in), .gpt_evt(gpt_evt), .irq_o(irq_o),
  .status(status), .en(en_q), .gen(gen_q), .hold(hold)
);

// File: tb/sim_irq_gather.sv
`timescale 1ns/1ps
module sim_irq_gather;
  localparam int PS = 3;
  localparam logic [9:0] STK = 10'b01_1111_1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic phy_irq = 0, dma_irq = 0, gpt_evt = 0, mberr_evt = 0, sberr_evt = 0, wake_irq = 0;
  logic [2:0] gpio_in = '0;
  logic irq_o;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  irq_gather #(.PRESCALE(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_irq(phy_irq),
    .dma_irq(dma_irq), .gpio_in(gpio_in), .gpt_evt(gpt_evt),
    .mberr_evt(mberr_evt), .sberr_evt(sberr_evt), .wake_irq(wake_irq), .irq_o(irq_o)
  );

  function automatic logic [9:0] pass_bits(input logic p, input logic d, input logic w);
    return {w, 7'b0, d, p};
  endfunction

  function automatic logic exp_req(input logic [9:0] st, input logic [9:0] en, input logic g);
    return (|(st & en)) & g;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [9:0] sticky_m, en_m, cur, setv, clrv;
    logic [2:0] gprev;
    logic req_prev;
    int k;
    void'($urandom(32'h1234_5678));
    step(); step();
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, d); check("R11 status", d, 0);
    rd(1, d); check("R11 enable", d, 0);
    rd(2, d); check("R11 config", d, 0);
    check("R11 irq", irq_o, 0);

    wr(1, 32'h0001_0000);
    rd(0, d); check("R5 sw set", d, 32'h20);
    rd(1, d); check("R5 req reads 0", d, 0);
    check("R1 irq masked", irq_o, 0);
    wr(0, 0);
    rd(0, d); check("R2 write 0 keeps", d, 32'h20);
    wr(0, 32'h20);
    rd(0, d); check("R2 w1c", d, 0);

    gpio_in = 3'b010; step();
    rd(0, d); check("R3 gpio1 rise", d, 32'h8);
    wr(0, 32'h8); step(); step();
    rd(0, d); check("R3 held level no reset", d, 0);
    gpio_in = 3'b000; step();

    phy_irq = 1; dma_irq = 1; wake_irq = 1;
    rd(0, d); check("R4 pass through", d, 32'h203);
    wr(0, 32'h3FF);
    rd(0, d); check("R4 write ignored", d, 32'h203);
    phy_irq = 0; dma_irq = 0; wake_irq = 0;
    rd(0, d); check("R4 follows low", d, 0);

    reg_addr = 0; reg_wdata = 32'h40; reg_wr = 1; gpt_evt = 1;
    step();
    reg_wr = 0; gpt_evt = 0;
    rd(0, d); check("R10 set wins", d, 32'h40);
    wr(0, 32'h40);
    rd(0, d); check("R10 later clear", d, 0);

    wr(1, 32'h080);
    mberr_evt = 1; step(); mberr_evt = 0;
    step(); step();
    check("R6 global off", irq_o, 0);
    rd(0, d); check("R1 raw with gate off", d, 32'h80);
    wr(1, 32'h8000_0080);
    check("R6 one edge lag", irq_o, 0);
    step();
    check("R6 irq on", irq_o, 1);
    wr(0, 32'h80);
    step();
    check("R6 irq off", irq_o, 0);
    mberr_evt = 1; step(); mberr_evt = 0;
    step();
    check("R8 no hold", irq_o, 1);
    rd(2, d); check("R8 hold flag 0", d, 0);

    wr(2, 5);
    wr(0, 32'h80);
    step();
    mberr_evt = 1; step(); mberr_evt = 0;
    for (int i = 2; i <= 16; i++) begin
      step();
      if (i == 14) begin
        rd(2, d); check("R7 hold flag", d, 32'h105);
        check("R7 low k14", irq_o, 0);
      end
      if (i == 15) check("R7 low k15", irq_o, 0);
      if (i == 16) check("R7 release", irq_o, 1);
    end

    wr(2, 255);
    wr(0, 32'h80);
    step();
    k = 0;
    mberr_evt = 1;
    do begin
      step(); mberr_evt = 0; k++;
    end while (!irq_o && k < 2000);
    check("R7 max interval", k, 255 * PS + 1);

    wr(2, 5);
    wr(0, 32'h80);
    step();
    mberr_evt = 1; step(); mberr_evt = 0;
    wr(2, 32'h205);
    rd(2, d); check("R9 flag cleared", d, 5);
    check("R9 low at clear", irq_o, 0);
    step();
    check("R9 release", irq_o, 1);

    wr(2, 0);
    wr(0, 32'h3FF);
    en_m = 10'($urandom);
    wr(1, {1'b1, 21'b0, en_m});
    step();
    sticky_m = '0; gprev = '0;
    reg_addr = 0;
    for (int n = 0; n < 3000; n++) begin
      phy_irq = ($urandom % 4) == 0; dma_irq = ($urandom % 4) == 0;
      wake_irq = ($urandom % 5) == 0;
      gpio_in = 3'($urandom);
      gpt_evt = ($urandom % 8) == 0; mberr_evt = ($urandom % 8) == 0;
      sberr_evt = ($urandom % 8) == 0;
      reg_wr = ($urandom % 4) == 0; reg_wdata = $urandom;
      cur = sticky_m | pass_bits(phy_irq, dma_irq, wake_irq);
      req_prev = exp_req(cur, en_m, 1'b1);
      setv = {1'b0, sberr_evt, mberr_evt, gpt_evt, 1'b0, gpio_in & ~gprev, 2'b00};
      clrv = reg_wr ? (reg_wdata[9:0] & STK) : '0;
      sticky_m = (sticky_m & ~clrv) | setv;
      gprev = gpio_in;
      step();
      reg_wr = 0;
      #1;
      check("R1 R2 R3 random status", reg_rdata, {22'b0, sticky_m | pass_bits(phy_irq, dma_irq, wake_irq)});
      check("R6 random irq", irq_o, req_prev);
    end
    finish_run();
  end
endmodule